// File: doc/BRIEF.md
# Fault Latch and Bus Alert Controller

This block keeps a sticky six-bit fault register for each power channel and drives one shared active-low alert line toward a two-wire management bus. Fault event strobes from the monitoring logic set bits in the register. A per-channel mask register, written by the host through the same register-write port, decides which bits may pull the alert low. The alert is edge-qualified. A bit raises it only when that bit goes from clear to set. A persisting or repeated fault therefore does not raise it again after the bus side has released it.

Fault bits are cleared in several ways: by a host write of zeros, by a falling edge of the channel's switch-on control, by a qualified undervoltage-reset input, by supply lockout, and by a falling edge of the channel's enable input. The enable-input clear also sets its own change bit. A bit whose live status input is still high cannot be cleared by any of these. The bus engine reports two events to the block: that an alert response was served, and that this device was addressed. Either event releases the alert. The alert also withdraws one cycle after the fault bits that raised it have all been cleared.

Top module: `fault_alert_ctrl`

## Requirements
- R1: After reset, every fault bit and every mask bit is zero, `alert_n` is 1 and `alert_pend` is 0.
- R2: A one-cycle pulse on a `fault_evt` bit sets the matching fault bit (channel c, bit b at index c*6+b) on that clock edge. The bit stays set after the pulse ends.
- R3: A fault bit whose mask bit is 0 sets the fault register without touching `alert_n`. When the mask bit is 1, `alert_n` goes low and `alert_pend` goes high on the same edge as the fault bit.
- R4: A one-cycle `ara_served` pulse returns `alert_n` to 1 and `alert_pend` to 0. The fault bits are left unchanged.
- R5: A one-cycle `dev_addressed` pulse while the alert is active also returns `alert_n` to 1.
- R6: After a release, a new event on a fault bit that is already set does not raise the alert again. A different enabled bit that newly sets does raise it, and so does the same bit once it has been cleared and then set again.
- R7: A host write with `reg_addr[0]`=0 targets the fault register of channel `reg_addr[ADDR_W-1:1]`. Each data bit written as 0 clears that fault bit, and each bit written as 1 leaves it unchanged. With `reg_addr[0]`=1 the data is loaded into that channel's mask.
- R8: A falling edge of `sw_on[c]` clears all six fault bits of channel c. Other channels are unaffected.
- R9: `uv_rst[c]` clears channel c's fault bits only when it has been high for UV_QUAL_CYC+1 consecutive clock edges. A shorter high period has no effect, and the count restarts every time the input goes low.
- R10: A cycle with `uvlo` high clears the fault bits of every channel.
- R11: A falling edge of `en_pin[c]` clears bits 0 to 3 and 5 of channel c and sets bit 4.
- R12: A fault bit whose `live_stat` bit is 1 stays set through a host clear, a switch-off, an undervoltage-reset or a lockout clear.
- R13: When a set event and a host clear hit the same bit on the same edge, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Host register write strobe |
| reg_addr | input | ADDR_W | Bit 0 selects fault (0) or mask (1); upper bits select the channel |
| reg_wdata | input | 6 | Host write data |
| sw_on | input | NUM_CH | Per-channel switch-on control level |
| uv_rst | input | NUM_CH | Per-channel undervoltage-reset level |
| uvlo | input | 1 | Supply lockout, clears every channel |
| en_pin | input | NUM_CH | Per-channel enable input level |
| fault_evt | input | NUM_CH*6 | Fault set strobes |
| live_stat | input | NUM_CH*6 | Live fault status levels |
| ara_served | input | 1 | Alert response address served strobe |
| dev_addressed | input | 1 | Device addressed strobe |
| fault_q | output | NUM_CH*6 | Fault register contents |
| mask_q | output | NUM_CH*6 | Alert mask register contents |
| alert_n | output | 1 | Active-low alert, 1 when inactive |
| alert_pend | output | 1 | Alert pending flag for the bus side |

## Verification
The assertions assume that `sw_on` and `en_pin` are steady levels coming from synchronised logic, that `fault_evt`, `ara_served` and `dev_addressed` are single-cycle strobes, and that UV_QUAL_CYC is at least 1. The stimulus drives every input away from the clock edge. It pulses strobes for exactly one cycle and changes the switch and enable levels only after they have settled for several cycles. The undervoltage input is held high either well short of the qualification window or beyond it, so no check relies on the exact edge where qualification completes.

// File: rtl/fltalert_pkg.sv
// Shared constants and types for the fault latch and alert controller.
// Assumes six fault bits per channel, with bit 4 reserved for the enable-change flag.
package fltalert_pkg;
    localparam int FAULT_W    = 6;
    localparam int EN_CHG_BIT = 4;
    typedef logic [FAULT_W-1:0] fault_vec_t;
    localparam fault_vec_t EN_CHG_MASK = fault_vec_t'(1) << EN_CHG_BIT;
    localparam fault_vec_t EN_FALL_CLR = ~EN_CHG_MASK;
endpackage

// File: rtl/fltalert_uv_qual.sv
// Undervoltage-reset qualifier. It counts consecutive cycles with uv_in high
// and flags a clear once the count reaches QUAL_CYC. The count restarts
// whenever uv_in is low. Assumes QUAL_CYC >= 1.
module fltalert_uv_qual #(
    parameter int QUAL_CYC = 200,
    localparam int CW = $clog2(QUAL_CYC + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic uv_in,
    output logic uv_clr
);
    logic [CW-1:0] cnt;

    // Count high cycles, saturating at QUAL_CYC, and restart when the input drops.
    always_ff @(posedge clk) begin
        if (!rst_n)                   cnt <= '0;
        else if (!uv_in)              cnt <= '0;
        else if (cnt != CW'(QUAL_CYC)) cnt <= cnt + 1'b1;
    end

    assign uv_clr = uv_in && (cnt == CW'(QUAL_CYC));

    assert_uv_needs_history_R9: assert property (@(posedge clk) disable iff (!rst_n)
        uv_clr |-> $past(uv_in));
    assert_uv_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !uv_in |=> !uv_clr);
endmodule

// File: rtl/fltalert_chan.sv
// One channel: sticky fault register, alert mask register and all clear sources.
// Assumes sw_on and en_pin are synchronous levels and fault_evt bits are strobes.
// A set always wins over a clear, and a live status bit blocks every clear.
module fltalert_chan
    import fltalert_pkg::*;
#(
    parameter int UV_QUAL_CYC = 200
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       host_wr,
    input  logic       mask_wr,
    input  fault_vec_t host_data,
    input  logic       sw_on,
    input  logic       uv_rst,
    input  logic       uvlo,
    input  logic       en_pin,
    input  fault_vec_t evt,
    input  fault_vec_t live,
    output fault_vec_t fault_q,
    output fault_vec_t mask_q,
    output fault_vec_t rise
);
    logic       sw_prev, en_prev;
    logic       sw_fall, en_fall, uv_clr, clr_all;
    fault_vec_t set_req, clr_req, clr_eff, fault_nxt;

    fltalert_uv_qual #(.QUAL_CYC(UV_QUAL_CYC)) u_uv (
        .clk    (clk),
        .rst_n  (rst_n),
        .uv_in  (uv_rst),
        .uv_clr (uv_clr)
    );

    // Remember the previous switch and enable levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sw_prev <= 1'b0;
            en_prev <= 1'b0;
        end else begin
            sw_prev <= sw_on;
            en_prev <= en_pin;
        end
    end

    assign sw_fall = sw_prev && !sw_on;
    assign en_fall = en_prev && !en_pin;
    assign clr_all = sw_fall || uv_clr || uvlo;

    // Gather the set and clear requests, then let live status veto clears.
    always_comb begin
        set_req = evt | (en_fall ? EN_CHG_MASK : '0);
        clr_req = (clr_all ? '1 : '0)
                | (host_wr ? ~host_data : '0)
                | (en_fall ? EN_FALL_CLR : '0);
        clr_eff   = clr_req & ~live;
        fault_nxt = (fault_q & ~clr_eff) | set_req;
    end

    assign rise = set_req & ~fault_q;

    // Hold the fault register.
    always_ff @(posedge clk) begin
        if (!rst_n) fault_q <= '0;
        else        fault_q <= fault_nxt;
    end

    // Hold the alert mask register, loaded by host writes.
    always_ff @(posedge clk) begin
        if (!rst_n)       mask_q <= '0;
        else if (mask_wr) mask_q <= host_data;
    end

    assert_live_blocks_clear_R12: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(fault_q & live) & ~fault_q) == '0));
    assert_set_wins_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt) |=> ((fault_q & $past(evt)) == $past(evt)));
    assert_en_flag_R11: assert property (@(posedge clk) disable iff (!rst_n)
        en_fall |=> fault_q[EN_CHG_BIT]);
endmodule

// File: rtl/fltalert_alert.sv
// Edge-qualified alert tracker. It keeps one pending bit per fault bit. A
// pending bit is set only when its fault bit newly sets while masked in. The
// release strobes drop every pending bit, and a pending bit also drops once
// its fault bit reads clear. A new rise wins over a release on the same edge.
module fltalert_alert #(
    parameter int NBITS = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NBITS-1:0] rise,
    input  logic [NBITS-1:0] mask,
    input  logic [NBITS-1:0] faults,
    input  logic             ara_served,
    input  logic             dev_addressed,
    output logic             alert_n,
    output logic             alert_pend
);
    logic [NBITS-1:0] pend;
    logic             release_now;
    logic [NBITS-1:0] new_hit;

    assign new_hit     = rise & mask;
    assign release_now = ara_served || (dev_addressed && (|pend));

    // Track which fault bits currently hold the alert.
    always_ff @(posedge clk) begin
        if (!rst_n) pend <= '0;
        else        pend <= ((release_now ? '0 : pend) & faults) | new_hit;
    end

    assign alert_pend = |pend;
    assign alert_n    = ~alert_pend;

    assert_fall_needs_hit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(alert_n) |-> $past(|new_hit));
    assert_ara_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ara_served && !(|new_hit)) |=> alert_n);
    assert_addr_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_addressed && !(|new_hit)) |=> alert_n);
endmodule

// File: rtl/fault_alert_ctrl.sv
// Top level: per-channel fault latches plus one shared alert line.
// Host writes are decoded by reg_addr: bit 0 selects fault (0) or mask (1),
// the upper bits select the channel. Assumes all inputs are synchronous to clk.
module fault_alert_ctrl
    import fltalert_pkg::*;
#(
    parameter int NUM_CH      = 2,
    parameter int UV_QUAL_CYC = 200,
    localparam int CH_AW  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int ADDR_W = CH_AW + 1,
    localparam int VW     = NUM_CH * FAULT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [FAULT_W-1:0] reg_wdata,
    input  logic [NUM_CH-1:0] sw_on,
    input  logic [NUM_CH-1:0] uv_rst,
    input  logic              uvlo,
    input  logic [NUM_CH-1:0] en_pin,
    input  logic [VW-1:0]     fault_evt,
    input  logic [VW-1:0]     live_stat,
    input  logic              ara_served,
    input  logic              dev_addressed,
    output logic [VW-1:0]     fault_q,
    output logic [VW-1:0]     mask_q,
    output logic              alert_n,
    output logic              alert_pend
);
    logic [VW-1:0] rise_all;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic ch_hit, wr_fault, wr_mask;
        fault_vec_t ch_fault, ch_mask, ch_rise;

        assign ch_hit   = reg_wr && (reg_addr[ADDR_W-1:1] == CH_AW'(c));
        assign wr_fault = ch_hit && !reg_addr[0];
        assign wr_mask  = ch_hit &&  reg_addr[0];

        fltalert_chan #(.UV_QUAL_CYC(UV_QUAL_CYC)) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .host_wr   (wr_fault),
            .mask_wr   (wr_mask),
            .host_data (reg_wdata),
            .sw_on     (sw_on[c]),
            .uv_rst    (uv_rst[c]),
            .uvlo      (uvlo),
            .en_pin    (en_pin[c]),
            .evt       (fault_evt[c*FAULT_W +: FAULT_W]),
            .live      (live_stat[c*FAULT_W +: FAULT_W]),
            .fault_q   (ch_fault),
            .mask_q    (ch_mask),
            .rise      (ch_rise)
        );

        assign fault_q [c*FAULT_W +: FAULT_W] = ch_fault;
        assign mask_q  [c*FAULT_W +: FAULT_W] = ch_mask;
        assign rise_all[c*FAULT_W +: FAULT_W] = ch_rise;
    end

    fltalert_alert #(.NBITS(VW)) u_alert (
        .clk           (clk),
        .rst_n         (rst_n),
        .rise          (rise_all),
        .mask          (mask_q),
        .faults        (fault_q),
        .ara_served    (ara_served),
        .dev_addressed (dev_addressed),
        .alert_n       (alert_n),
        .alert_pend    (alert_pend)
    );

    assert_lockout_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (uvlo && !(|fault_evt) && !(|live_stat)) |=> (fault_q == '0));
endmodule

// File: tb/fault_alert_ctrl_bench.sv
// Directed bench: one task per scenario, each checking its own results.
module fault_alert_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 2;
    localparam int UVQ = 200;
    localparam int VW  = NCH * 6;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          reg_wr;
    logic [1:0]    reg_addr;
    logic [5:0]    reg_wdata;
    logic [NCH-1:0] sw_on, uv_rst, en_pin;
    logic          uvlo, ara_served, dev_addressed;
    logic [VW-1:0] fault_evt, live_stat;
    logic [VW-1:0] fault_q, mask_q;
    logic          alert_n, alert_pend;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fault_alert_ctrl #(.NUM_CH(NCH), .UV_QUAL_CYC(UVQ)) u_fault_alert_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .sw_on(sw_on), .uv_rst(uv_rst), .uvlo(uvlo),
        .en_pin(en_pin), .fault_evt(fault_evt), .live_stat(live_stat),
        .ara_served(ara_served), .dev_addressed(dev_addressed),
        .fault_q(fault_q), .mask_q(mask_q), .alert_n(alert_n), .alert_pend(alert_pend)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [5:0] chf(input int c);
        return fault_q[c*6 +: 6];
    endfunction

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
        sw_on = '0; uv_rst = '0; uvlo = 1'b0; en_pin = '1;
        fault_evt = '0; live_stat = '0; ara_served = 1'b0; dev_addressed = 1'b0;
        cyc(2);
        rst_n = 1'b1;
        cyc(1);
    endtask

    task automatic wr(input logic [1:0] a, input logic [5:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        cyc(1);
        reg_wr = 1'b0;
    endtask

    task automatic evt(input int c, input logic [5:0] b);
        fault_evt[c*6 +: 6] = b;
        cyc(1);
        fault_evt = '0;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 fault", 32'(fault_q), 0);
        chk("R1 mask", 32'(mask_q), 0);
        chk("R1 alert_n", 32'(alert_n), 1);
        chk("R1 pend", 32'(alert_pend), 0);
    endtask

    task automatic t_set_mask();
        do_reset();
        evt(1, 6'b100000);
        chk("R2 sticky set", 32'(chf(1)), 6'b100000);
        chk("R3 unmasked no alert", 32'(alert_n), 1);
        cyc(3);
        chk("R2 stays set", 32'(chf(1)), 6'b100000);
        wr(2'b11, 6'b000010);
        chk("R7 mask load", 32'(mask_q[11:6]), 6'b000010);
        evt(1, 6'b000010);
        chk("R3 masked alert", 32'(alert_n), 0);
        chk("R3 pend", 32'(alert_pend), 1);
    endtask

    task automatic t_ara();
        do_reset();
        wr(2'b01, 6'b000001);
        evt(0, 6'b000001);
        chk("R3 alert low", 32'(alert_n), 0);
        ara_served = 1'b1; cyc(1); ara_served = 1'b0;
        chk("R4 released", 32'(alert_n), 1);
        chk("R4 pend clear", 32'(alert_pend), 0);
        chk("R4 fault kept", 32'(chf(0)), 6'b000001);
    endtask

    task automatic t_addr();
        do_reset();
        wr(2'b11, 6'b111111);
        evt(1, 6'b000100);
        chk("R5 alert low", 32'(alert_n), 0);
        dev_addressed = 1'b1; cyc(1); dev_addressed = 1'b0;
        chk("R5 released", 32'(alert_n), 1);
        evt(1, 6'b001000);
        chk("R5 new alert", 32'(alert_n), 0);
    endtask

    task automatic t_no_rearm();
        do_reset();
        wr(2'b01, 6'b000011);
        evt(0, 6'b000001);
        ara_served = 1'b1; cyc(1); ara_served = 1'b0;
        evt(0, 6'b000001);
        chk("R6 no rearm same bit", 32'(alert_n), 1);
        evt(0, 6'b000010);
        chk("R6 other bit raises", 32'(alert_n), 0);
        ara_served = 1'b1; cyc(1); ara_served = 1'b0;
        wr(2'b00, 6'b111110);
        chk("R7 zero clears bit0", 32'(chf(0)), 6'b000010);
        evt(0, 6'b000001);
        chk("R6 cleared bit rearms", 32'(alert_n), 0);
    endtask

    task automatic t_host_clear();
        do_reset();
        evt(1, 6'b000011);
        wr(2'b10, 6'b111111);
        chk("R7 ones keep", 32'(chf(1)), 6'b000011);
        wr(2'b10, 6'b111101);
        chk("R7 zero clears", 32'(chf(1)), 6'b000001);
        chk("R7 other channel", 32'(chf(0)), 0);
    endtask

    task automatic t_sw_off();
        do_reset();
        sw_on = 2'b11; cyc(3);
        evt(0, 6'b101010);
        evt(1, 6'b010101);
        sw_on[0] = 1'b0; cyc(1);
        chk("R8 ch0 cleared", 32'(chf(0)), 0);
        chk("R8 ch1 kept", 32'(chf(1)), 6'b010101);
    endtask

    task automatic t_uv();
        do_reset();
        evt(0, 6'b000001);
        uv_rst[0] = 1'b1; cyc(UVQ / 2); uv_rst[0] = 1'b0; cyc(1);
        uv_rst[0] = 1'b1; cyc(UVQ / 2); uv_rst[0] = 1'b0; cyc(1);
        chk("R9 short pulses ignored", 32'(chf(0)), 6'b000001);
        uv_rst[0] = 1'b1; cyc(UVQ + 5); uv_rst[0] = 1'b0; cyc(1);
        chk("R9 qualified clear", 32'(chf(0)), 0);
    endtask

    task automatic t_uvlo();
        do_reset();
        evt(0, 6'b111111);
        evt(1, 6'b001100);
        uvlo = 1'b1; cyc(1); uvlo = 1'b0;
        chk("R10 all cleared", 32'(fault_q), 0);
    endtask

    task automatic t_en_fall();
        do_reset();
        evt(1, 6'b100111);
        en_pin[1] = 1'b0; cyc(1);
        chk("R11 en change", 32'(chf(1)), 6'b010000);
        chk("R11 ch0 untouched", 32'(chf(0)), 0);
    endtask

    task automatic t_live();
        do_reset();
        live_stat[2] = 1'b1;
        evt(0, 6'b000101);
        wr(2'b00, 6'b000000);
        chk("R12 host blocked", 32'(chf(0)), 6'b000100);
        uvlo = 1'b1; cyc(1); uvlo = 1'b0;
        chk("R12 lockout blocked", 32'(chf(0)), 6'b000100);
        live_stat = '0;
        wr(2'b00, 6'b000000);
        chk("R12 clears after live drop", 32'(chf(0)), 0);
    endtask

    task automatic t_set_vs_clear();
        do_reset();
        fault_evt[3] = 1'b1;
        wr(2'b00, 6'b000000);
        fault_evt = '0;
        chk("R13 set wins", 32'(chf(0)), 6'b001000);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_set_mask();
        t_ara();
        t_addr();
        t_no_rearm();
        t_host_clear();
        t_sw_off();
        t_uv();
        t_uvlo();
        t_en_fall();
        t_live();
        t_set_vs_clear();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule